// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, a segment number and an offset inside that segment, into a flat physical address. It keeps a small table with one entry per segment. Each entry holds a base (where the segment starts in physical memory), a limit (the segment's length) and three permission bits. A separate length register says how many segments are in use.

Each request carries a segment number, an offset and an access kind. The block runs three checks. The segment number must be below the length register. The offset must be below the segment's limit. The segment must grant the requested kind of access. If all three pass, the result is the base plus the offset. If any check fails, the block reports a trap with a cause code instead.

The checks are combinational. The result is registered, so it appears one cycle after the request. Software loads the table and the length register through simple write-enable inputs.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid, rsp_cause and rsp_paddr are all zero. Reset also clears the length register to 0 and every table entry to zero, so every request traps with cause 1 until the table is loaded.
- R2: A request accepted on a rising edge (req_valid high) gives rsp_valid high for exactly the following cycle. The result for that request is visible in the same cycle. rsp_valid is low after any cycle without a request.
- R3: If the segment number is greater than or equal to the length register, the response cause is 1 (bad segment number).
- R4: If the segment number is legal and the offset is greater than or equal to that segment's limit, the cause is 2 (offset overflow). A limit of 0 rejects every offset. An offset of limit-1 is accepted.
- R5: Access kind encoding: 0 = read, 1 = write, 2 = execute, 3 = reserved. The permission field has bit 0 = read, bit 1 = write, bit 2 = execute. If the addressed bit is clear, or the kind is 3, the cause is 3 (permission violation).
- R6: When several checks fail, the lowest nonzero cause code is reported: a bad segment number beats an offset overflow, which beats a permission violation.
- R7: When no check fails, the cause is 0 and rsp_paddr equals base + offset, taken modulo 2^PA_W.
- R8: Whenever the cause is nonzero, rsp_paddr is 0.
- R9: A table-entry write or length write in the same cycle as a request does not affect that request. It applies to requests from the next cycle onward.
- R10: In cycles without a request, rsp_cause and rsp_paddr hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Write one table entry |
| tbl_idx | input | SEG_W | Index of the entry to write |
| tbl_base | input | PA_W | Base physical address to write |
| tbl_limit | input | OFF_W | Segment length to write |
| tbl_perm | input | 3 | Permission bits to write (bit 0 read, bit 1 write, bit 2 execute) |
| len_we | input | 1 | Write the length register |
| len_val | input | SEG_W+1 | New number of segments in use |
| req_valid | input | 1 | Translation request |
| req_seg | input | SEG_W | Segment number of the request |
| req_off | input | OFF_W | Offset inside the segment |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_cause | output | 2 | Trap cause (0 none, 1 segment, 2 offset, 3 permission) |
| rsp_paddr | output | PA_W | Physical address, 0 on a trap |

## Verification
The bench targets the edges of each bound:
- **Segment boundary.** It uses the segment just below and just above the length register. A design that compared with "less than or equal" would translate a segment that does not exist.
- **Limit boundary.** It uses offsets of limit-1 and limit, plus an entry with limit 0. An off-by-one here would either leak one location past the segment or lose the last one.
- **Check priority.** Requests that fail two or three checks at once expose a wrong priority as the wrong cause code.
- **Same-cycle write.** A table write landing in the same cycle as a request to the same entry exposes a design that forwards write data into the live lookup.
- **Reserved kind, address wrap and hold.** Further checks cover the reserved access kind, a base + offset sum that wraps, and outputs held through idle cycles.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 8,
  parameter int PA_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [SEG_W-1:0] tbl_idx,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [OFF_W-1:0] tbl_limit,
  input  logic [2:0]       tbl_perm,
  input  logic             len_we,
  input  logic [SEG_W:0]   len_val,
  input  logic             req_valid,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_kind,
  output logic             rsp_valid,
  output logic [1:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr
);
  localparam int NSEG = 1 << SEG_W;

  logic [PA_W-1:0]  base_q  [NSEG];
  logic [OFF_W-1:0] limit_q [NSEG];
  logic [2:0]       perm_q  [NSEG];
  logic [SEG_W:0]   seg_len_q;

  logic       seg_ok, off_ok, kind_ok;
  logic [2:0] perm_sel;
  logic [1:0] cause_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_len_q <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        perm_q[i]  <= '0;
      end
    end else begin
      if (len_we) seg_len_q <= len_val;
      if (tbl_we) begin
        base_q[tbl_idx]  <= tbl_base;
        limit_q[tbl_idx] <= tbl_limit;
        perm_q[tbl_idx]  <= tbl_perm;
      end
    end
  end

  assign perm_sel = perm_q[req_seg];
  assign seg_ok   = {1'b0, req_seg} < seg_len_q;
  assign off_ok   = req_off < limit_q[req_seg];

  always_comb begin
    case (req_kind)
      2'd0:    kind_ok = perm_sel[0];
      2'd1:    kind_ok = perm_sel[1];
      2'd2:    kind_ok = perm_sel[2];
      default: kind_ok = 1'b0;
    endcase
  end

  assign cause_d = !seg_ok  ? 2'd1 :
                   !off_ok  ? 2'd2 :
                   !kind_ok ? 2'd3 : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_cause <= 2'd0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_cause <= cause_d;
        rsp_paddr <= (cause_d == 2'd0) ? base_q[req_seg] + PA_W'(req_off) : '0;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r3_bad_segment: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_seg} >= seg_len_q)) |=> rsp_cause == 2'd1);
  a_r4_offset_over: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_seg} < seg_len_q) && (req_off >= limit_q[req_seg]))
      |=> rsp_cause == 2'd2);
  a_r8_trap_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_cause != 2'd0) |-> rsp_paddr == '0);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_cause) && $stable(rsp_paddr)));
endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam int SEG_W = 3, OFF_W = 8, PA_W = 12;
  localparam int NSEG = 1 << SEG_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 0, len_we = 0, req_valid = 0;
  logic [SEG_W-1:0] tbl_idx = '0, req_seg = '0;
  logic [PA_W-1:0]  tbl_base = '0;
  logic [OFF_W-1:0] tbl_limit = '0, req_off = '0;
  logic [2:0]       tbl_perm = '0;
  logic [SEG_W:0]   len_val = '0;
  logic [1:0]       req_kind = '0;
  logic             rsp_valid;
  logic [1:0]       rsp_cause;
  logic [PA_W-1:0]  rsp_paddr;

  int checks = 0, fails = 0;

  logic [PA_W-1:0]  m_base  [NSEG];
  logic [OFF_W-1:0] m_limit [NSEG];
  logic [2:0]       m_perm  [NSEG];
  logic [SEG_W:0]   m_len;
  logic [1:0]       e_cause;
  logic [PA_W-1:0]  e_paddr;

  always #10 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .tbl_perm(tbl_perm), .len_we(len_we), .len_val(len_val),
    .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr));

  function automatic logic [1:0] exp_cause(input logic [SEG_W-1:0] s,
      input logic [OFF_W-1:0] o, input logic [1:0] k);
    if ({1'b0, s} >= m_len) return 2'd1;
    if (o >= m_limit[s]) return 2'd2;
    if (k == 2'd3 || !m_perm[s][k]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'd0: return "R7";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic ok, input string what,
      input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic tick(input string tag);
    logic exp_v;
    string t;
    exp_v = req_valid;
    if (req_valid) begin
      e_cause = exp_cause(req_seg, req_off, req_kind);
      e_paddr = (e_cause == 2'd0) ? m_base[req_seg] + PA_W'(req_off) : '0;
    end
    t = (tag == "") ? (req_valid ? tag_of(e_cause) : "R10") : tag;
    @(posedge clk);
    if (len_we) m_len = len_val;
    if (tbl_we) begin
      m_base[tbl_idx] = tbl_base; m_limit[tbl_idx] = tbl_limit; m_perm[tbl_idx] = tbl_perm;
    end
    @(negedge clk);
    check("R2", rsp_valid == exp_v, "rsp_valid", rsp_valid, exp_v);
    check(t, rsp_cause == e_cause, "rsp_cause", rsp_cause, e_cause);
    check((e_cause != 0) ? "R8" : t, rsp_paddr == e_paddr, "rsp_paddr", rsp_paddr, e_paddr);
    tbl_we = 0; len_we = 0; req_valid = 0;
  endtask

  task automatic wr(input int i, input int b, input int l, input int p);
    tbl_we = 1; tbl_idx = i[SEG_W-1:0]; tbl_base = b[PA_W-1:0];
    tbl_limit = l[OFF_W-1:0]; tbl_perm = p[2:0];
  endtask

  task automatic rq(input int s, input int o, input int k);
    req_valid = 1; req_seg = s[SEG_W-1:0]; req_off = o[OFF_W-1:0]; req_kind = k[1:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NSEG; i++) begin m_base[i] = 0; m_limit[i] = 0; m_perm[i] = 0; end
    m_len = 0; e_cause = 0; e_paddr = 0;
    repeat (3) @(negedge clk);
    check("R1", rsp_valid == 0, "rsp_valid", rsp_valid, 0);
    check("R1", rsp_cause == 0, "rsp_cause", rsp_cause, 0);
    check("R1", rsp_paddr == 0, "rsp_paddr", rsp_paddr, 0);
    rst_n = 1;
    @(negedge clk);
    rq(0, 0, 0); tick("R1");
    for (int i = 0; i < NSEG; i++) begin
      wr(i, 100 * i + 5, 16 + i, (i % 7) + 1); tick("");
    end
    len_we = 1; len_val = 6; tick("");
    rq(5, 3, 0); tick("R3");
    rq(6, 3, 0); tick("R3");
    rq(7, 0, 0); tick("R3");
    rq(0, 15, 0); tick("R4");
    rq(0, 16, 0); tick("R4");
    wr(1, 50, 0, 7); tick("");
    rq(1, 0, 0); tick("R4");
    wr(2, 10, 40, 3'b011); tick("");
    rq(2, 1, 2); tick("R5");
    rq(2, 1, 3); tick("R5");
    rq(2, 1, 1); tick("R7");
    wr(3, 12'hFF0, 200, 3'b111); tick("");
    rq(3, 100, 2); tick("R7");
    rq(7, 255, 3); tick("R6");
    wr(4, 0, 4, 3'b000); tick("");
    rq(4, 9, 3); tick("R6");
    rq(4, 2, 0); tick("R6");
    rq(2, 5, 0); wr(2, 300, 1, 3'b000); tick("R9");
    rq(2, 5, 0); tick("R9");
    rq(6, 0, 0); len_we = 1; len_val = 8; tick("R9");
    wr(6, 7, 9, 3'b001); tick("");
    rq(6, 0, 0); tick("R9");
    tick("R10"); tick("R10");
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0)
        wr($urandom_range(0, NSEG - 1), $urandom, $urandom_range(0, 255), $urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) begin len_we = 1; len_val = (SEG_W+1)'($urandom_range(0, NSEG)); end
      if ($urandom_range(0, 4) != 0)
        rq($urandom_range(0, NSEG - 1), $urandom_range(0, 255), $urandom_range(0, 3));
      tick("");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule